// File: doc/BRIEF.md
# Restoring Shift-Subtract Divider

This block divides one unsigned 32-bit operand by another over several clock cycles, one quotient bit per cycle. Each operation goes through four phases. The operands are captured. A single left shift then primes the working register. Thirty-two trial subtractions follow. A last cycle corrects the upper half. The working register holds the partial remainder in its upper part and the dividend in its lower part. Quotient bits enter the register from the right while the dividend bits leave it on the left.

A client raises `start` for one cycle with both operands while the block is idle. `busy` stays high until the operation ends. A one-cycle `done` pulse marks the cycle in which `quotient` (the low word) and `remainder` (the high word) are final. The results and the zero-divisor flag then hold until the next accepted request. A zero divisor is not treated as an error. The operation runs its full course and reports an all-ones quotient, the dividend as remainder, and a raised `div_by_zero`.

Top module: `shift_sub_divider`

## Requirements
- R1: When `start` is high at a rising edge while `busy` is low, the request is accepted and `busy` is high after that edge.
- R2: Counting the accepting edge as the first, `done` is high after rising edge number WIDTH+3 (35 for the default width). It is low in every earlier cycle of the operation.
- R3: For a nonzero divisor, in the `done` cycle `quotient` equals floor(dividend / divisor), `remainder` equals dividend mod divisor, and `remainder` is less than the divisor.
- R4: For a zero divisor, in the `done` cycle `quotient` is all ones, `remainder` equals the dividend, and `div_by_zero` is 1. For a nonzero divisor `div_by_zero` is 0.
- R5: A `start` that arrives while `busy` is high, including in the `done` cycle, is ignored. The running operation finishes with its original operands and its original timing.
- R6: While idle with `start` low, `quotient`, `remainder` and `div_by_zero` keep the values they had in the `done` cycle, whatever the operand inputs do.
- R7: While `rst_n` is low, and after it is released, `busy`, `done`, `div_by_zero`, `quotient` and `remainder` are all 0 until a request is accepted. A reset in the middle of an operation aborts it.
- R8: `done` is high for exactly one cycle, and `busy` is low in the cycle after it.
- R9: Results are exact for divisors with the most significant bit set, and for dividends with all bits set, where the shifted partial remainder needs one bit more than a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a division; accepted only when idle |
| dividend | input | 32 | Unsigned dividend, sampled on the accepting edge |
| divisor | input | 32 | Unsigned divisor, sampled on the accepting edge |
| busy | output | 1 | Operation in progress, including the done cycle |
| done | output | 1 | One-cycle pulse; results are final in this cycle |
| quotient | output | 32 | Quotient (low word of the working register) |
| remainder | output | 32 | Remainder (high word of the working register) |
| div_by_zero | output | 1 | The divisor of the finished operation was zero |

## Verification
The hardest case to reach from the ports is the one where the shifted partial remainder overflows a word. This happens only when the divisor has its top bit set and the upper half has grown past 2^31. The operand table therefore includes pairs such as 0x80000000 / 0x80000001, 0xFFFFFFFF / 0x80000000 and 0xFFFFFFFE / 0xFFFFFFFF. A second case that needs careful timing is a request arriving while an operation is in flight. Directed tests pulse `start` with different operands in the middle of the run and again in the done cycle. They then confirm that the latency and the results still belong to the first operation.

// File: rtl/rdiv_pkg.sv
package rdiv_pkg;

  // Phases of one division
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_PRIME = 3'd1,
    PH_STEP  = 3'd2,
    PH_FIX   = 3'd3,
    PH_DONE  = 3'd4
  } rdiv_phase_e;

endpackage

// File: rtl/rdiv_ctrl.sv
module rdiv_ctrl
  import rdiv_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load_en,
  output logic prime_en,
  output logic step_en,
  output logic fix_en,
  output logic busy,
  output logic done
);

  localparam int CNT_W = $clog2(WIDTH + 1);
  localparam int LAT_W = $clog2(WIDTH + 4) + 1;
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(WIDTH - 1);
  localparam logic [LAT_W-1:0] LATENCY   = LAT_W'(WIDTH + 3);

  rdiv_phase_e      phase_q, phase_d;
  logic [CNT_W-1:0] step_cnt_q;
  logic             last_step;

  assign busy      = (phase_q != PH_IDLE);
  assign load_en   = start && !busy;
  assign prime_en  = (phase_q == PH_PRIME);
  assign step_en   = (phase_q == PH_STEP);
  assign fix_en    = (phase_q == PH_FIX);
  assign done      = (phase_q == PH_DONE);
  assign last_step = step_en && (step_cnt_q == LAST_STEP);

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE:  if (start)     phase_d = PH_PRIME;
      PH_PRIME:                phase_d = PH_STEP;
      PH_STEP:  if (last_step) phase_d = PH_FIX;
      PH_FIX:                  phase_d = PH_DONE;
      PH_DONE:                 phase_d = PH_IDLE;
      default:                 phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q    <= PH_IDLE;
      step_cnt_q <= '0;
    end else begin
      phase_q <= phase_d;
      if (prime_en)     step_cnt_q <= '0;
      else if (step_en) step_cnt_q <= step_cnt_q + 1'b1;
    end
  end

  // Latency observer for the assertions
  logic [LAT_W-1:0] lat_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lat_q <= '0;
    else if (load_en) lat_q <= LAT_W'(1);
    else if (busy)    lat_q <= lat_q + 1'b1;
  end

  // R1: an accepted request makes the block busy
  p_accept_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> busy);

  // R2: done arrives exactly WIDTH+3 edges after acceptance
  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lat_q == LATENCY));

  // R2: the step counter never runs past the last step
  p_step_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    step_en |-> (step_cnt_q <= LAST_STEP));

  // R8: single-cycle done, then idle
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  // R5: a request while busy does not restart the sequence
  p_ignore_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !done) |=> busy);

endmodule

// File: rtl/rdiv_dp.sv
module rdiv_dp #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic             prime_en,
  input  logic             step_en,
  input  logic             fix_en,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder,
  output logic             div_by_zero,
  output logic             step_neg
);

  // Working register: guard bit, upper word, lower word
  localparam int ACC_W = 2 * WIDTH + 1;
  localparam int UP_W  = WIDTH + 1;

  logic [ACC_W-1:0] acc_q;
  logic [WIDTH-1:0] dvsr_q;
  logic             dbz_q;
  logic [UP_W:0]    trial;

  // Trial subtraction of the divisor from the upper part; top bit is the borrow
  function automatic logic [UP_W:0] trial_sub(input logic [UP_W-1:0] upper,
                                               input logic [WIDTH-1:0] d);
    return {1'b0, upper} - {2'b00, d};
  endfunction

  // One restoring step: keep the difference or the old upper part, shift in the bit
  function automatic logic [ACC_W-1:0] one_step(input logic [ACC_W-1:0] acc,
                                                input logic [UP_W:0]    diff);
    if (diff[UP_W])
      return {acc[ACC_W-2:0], 1'b0};
    else
      return {diff[WIDTH-1:0], acc[WIDTH-1:0], 1'b1};
  endfunction

  // Final correction: move only the upper part back right by one
  function automatic logic [ACC_W-1:0] fix_upper(input logic [ACC_W-1:0] acc);
    return {1'b0, acc[ACC_W-1:WIDTH+1], acc[WIDTH-1:0]};
  endfunction

  assign trial    = trial_sub(acc_q[ACC_W-1:WIDTH], dvsr_q);
  assign step_neg = step_en && trial[UP_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      dvsr_q <= '0;
      dbz_q  <= 1'b0;
    end else if (load_en) begin
      acc_q  <= {{UP_W{1'b0}}, dividend};
      dvsr_q <= divisor;
      dbz_q  <= (divisor == '0);
    end else if (prime_en) begin
      acc_q <= {acc_q[ACC_W-2:0], 1'b0};
    end else if (step_en) begin
      acc_q <= one_step(acc_q, trial);
    end else if (fix_en) begin
      acc_q <= fix_upper(acc_q);
    end
  end

  assign quotient    = acc_q[WIDTH-1:0];
  assign remainder   = acc_q[2*WIDTH-1:WIDTH];
  assign div_by_zero = dbz_q;

  // R3: the corrected remainder is below a nonzero divisor
  p_rem_below_div_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fix_en && !dbz_q) |=> (remainder < dvsr_q));

  // R4: a zero divisor yields an all-ones quotient
  p_zero_div_quot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fix_en && dbz_q) |=> (&quotient));

  // R5: the divisor is only captured on an accepted request
  p_divisor_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(dvsr_q));

  // R6: with no phase active the results do not move
  p_results_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && !prime_en && !step_en && !fix_en) |=>
      ($stable(quotient) && $stable(remainder) && $stable(div_by_zero)));

  // R9: a kept difference always fits in one word
  p_kept_diff_fits_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !step_neg) |-> (trial[WIDTH] == 1'b0));

  // R9: the guard bit is clear once the upper part is corrected
  p_guard_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fix_en |=> (acc_q[ACC_W-1] == 1'b0));

endmodule

// File: rtl/shift_sub_divider.sv
module shift_sub_divider #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder,
  output logic             div_by_zero
);

  logic load_en, prime_en, step_en, fix_en, step_neg;

  rdiv_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .load_en  (load_en),
    .prime_en (prime_en),
    .step_en  (step_en),
    .fix_en   (fix_en),
    .busy     (busy),
    .done     (done)
  );

  rdiv_dp #(.WIDTH(WIDTH)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_en     (load_en),
    .prime_en    (prime_en),
    .step_en     (step_en),
    .fix_en      (fix_en),
    .dividend    (dividend),
    .divisor     (divisor),
    .quotient    (quotient),
    .remainder   (remainder),
    .div_by_zero (div_by_zero),
    .step_neg    (step_neg)
  );

  // R7: out of reset nothing is running and the results read zero
  p_reset_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!done && !div_by_zero && quotient == '0 && remainder == '0));

  // R3: a restore step can only occur while stepping
  p_neg_only_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    step_neg |-> busy);

endmodule

// File: tb/test_shift_sub_divider.sv
module test_shift_sub_divider;

  localparam int W    = 32;
  localparam int LAT  = W + 3;
  localparam int NVEC = 12;

  // {dividend, divisor}
  localparam logic [63:0] VEC [NVEC] = '{
    64'h00000007_00000003,
    64'h00000064_00000007,
    64'h00000000_00000005,
    64'h00000005_00000007,
    64'hFFFFFFFF_00000001,
    64'hFFFFFFFF_FFFFFFFF,
    64'h80000000_80000001,
    64'hFFFFFFFF_80000000,
    64'hFFFFFFFE_FFFFFFFF,
    64'h12345678_00001000,
    64'hDEADBEEF_00000003,
    64'h00001234_00000000
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] dividend = '0;
  logic [W-1:0] divisor = '0;
  logic         busy, done, div_by_zero;
  logic [W-1:0] quotient, remainder;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  shift_sub_divider #(.WIDTH(W)) i_shift_sub_divider (
    .clk(clk), .rst_n(rst_n), .start(start),
    .dividend(dividend), .divisor(divisor),
    .busy(busy), .done(done), .quotient(quotient),
    .remainder(remainder), .div_by_zero(div_by_zero)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: got %0d cycles exp below 100000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %h exp %h", req, what, act, exp);
    end
  endtask

  // Issue a request and wait for done; returns latency in cycles
  task automatic launch(input logic [W-1:0] a, input logic [W-1:0] b,
                        output int lat);
    @(negedge clk);
    dividend = a; divisor = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 200) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic check_result(input logic [W-1:0] a, input logic [W-1:0] b,
                              input int lat, input string req);
    logic [W-1:0] eq, er;
    if (b == '0) begin
      eq = '1; er = a;
    end else begin
      eq = a / b; er = a % b;
    end
    check(lat == LAT, "R2", "latency", 64'(lat), 64'(LAT));
    check(quotient == eq, req, "quotient", 64'(quotient), 64'(eq));
    check(remainder == er, req, "remainder", 64'(remainder), 64'(er));
    check(div_by_zero == (b == '0), "R4", "div_by_zero",
          64'(div_by_zero), 64'(b == '0));
  endtask

  initial begin
    int lat;
    logic [W-1:0] hq, hr;

    // R7: reset state
    repeat (3) @(negedge clk);
    check(!busy && !done && !div_by_zero, "R7", "flags in reset",
          {61'b0, busy, done, div_by_zero}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(quotient == '0 && remainder == '0, "R7", "results after reset",
          {quotient, remainder}, 64'd0);

    // R3, R4, R9: operand table
    for (int i = 0; i < NVEC; i++) begin
      launch(VEC[i][63:32], VEC[i][31:0], lat);
      check_result(VEC[i][63:32], VEC[i][31:0], lat,
                   (VEC[i][31:0] == '0) ? "R4" : ((VEC[i][31] || VEC[i][63]) ? "R9" : "R3"));
      @(negedge clk);
      check(!done && !busy, "R8", "done pulse width", {62'b0, done, busy}, 64'd0);
    end

    // R1: busy rises after acceptance
    @(negedge clk);
    dividend = 32'd1000; divisor = 32'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy, "R1", "busy after start", 64'(busy), 64'd1);
    while (!done) @(negedge clk);
    check(quotient == '1 && remainder == 32'd1000 && div_by_zero, "R4",
          "1000/0", {quotient, remainder}, {32'hFFFFFFFF, 32'd1000});
    @(negedge clk);

    // R5: start while busy (mid-run and in done cycle) is ignored
    dividend = 32'd1000; divisor = 32'd7; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    repeat (5) begin @(negedge clk); lat++; end
    dividend = 32'd99; divisor = 32'd0; start = 1'b1;
    @(negedge clk); lat++;
    start = 1'b0;
    while (!done && lat < 200) begin @(negedge clk); lat++; end
    check_result(32'd1000, 32'd7, lat, "R5");
    dividend = 32'd55; divisor = 32'd5; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(!busy, "R5", "start in done cycle ignored", 64'(busy), 64'd0);

    // R6: results hold while idle with changing operands
    hq = quotient; hr = remainder;
    repeat (6) begin
      dividend = dividend + 32'h1111; divisor = divisor ^ 32'hFF;
      @(negedge clk);
    end
    check(quotient == hq && remainder == hr && !div_by_zero, "R6",
          "results held", {quotient, remainder}, {hq, hr});

    // R7: reset in mid operation aborts
    dividend = 32'hCAFEF00D; divisor = 32'd9; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(!busy && quotient == '0 && remainder == '0, "R7", "abort by reset",
          {quotient, remainder}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!busy && !done, "R7", "idle after abort", {62'b0, busy, done}, 64'd0);

    // R3: operation right after reset
    launch(32'd0, 32'hFFFFFFFF, lat);
    check_result(32'd0, 32'hFFFFFFFF, lat, "R3");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule